// File: doc/BRIEF.md
# Display Gamma Table Write Controller

This block turns register writes into updates of a display gamma lookup table. It holds two tables. The linear table has 256 entries with three 10-bit channels. The segment table has 128 entries with three 16-bit channels.

A small register set selects the table, sets the current entry index and sets a per-channel enable mask. Two data registers fill the table:

- **Sequential register.** It takes one colour component per write. A hidden component counter decides which channel the write lands in, and it moves the index on after the third component.
- **Packed register.** It writes all three 10-bit channels of a linear entry in one write.

After every write that stores at least one channel, the block emits a one-cycle update event. The event carries the table, the entry address and the full contents of that entry after the update. A downstream colour pipeline uses this event to mirror the table.

The write side is a valid/ready stream. `wr_ready` is held high, so a beat is accepted in every cycle where `wr_valid` is high, and the writer never sees back-pressure. The update side has no ready. A consumer must take `upd_valid` in the cycle it is high.

Top module: `gamma_lut_wr`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the mode, index, mask, component counter, error flag, update outputs and every entry of both tables to zero.
- R2: An accepted beat (`wr_valid` and `wr_ready`) is decoded by `wr_addr`: 0 = mode (bit 0, 0 = linear, 1 = segment), 1 = index (bits 7:0), 2 = mask (bits 2:0), 3 = sequential data, 4 = packed data. Addresses 5 to 7 change nothing. `wr_ready` is always 1, and the mode changes only on an address 0 write.
- R3: Sequential writes land in red, then green, then blue: component counter values 0, 1, 2 select channels red, green, blue. The write that stores blue returns the counter to 0 and advances the index by one.
- R4: Mask bit 0 enables blue, bit 1 enables green and bit 2 enables red. A sequential write to a disabled channel stores nothing, but the counter still advances and the index still steps after blue.
- R5: One cycle after a data write that stored at least one channel, `upd_valid` is high for one cycle. In that cycle `upd_pwl` gives the table, `upd_index` gives the entry and `upd_red`, `upd_green` and `upd_blue` give the whole entry after the write. No event follows a write that stored nothing.
- R6: In segment mode, a sequential write stores data bits 15:0 at entry `index[6:0]`. The event index has bit 7 clear. The index step wraps within bits 6:0 and leaves bit 7 as it was.
- R7: In linear mode, a packed write stores red = bits 29:20, green = bits 19:10 and blue = bits 9:0 into the enabled channels of the current entry. It then advances the index by one and clears the counter. A linear sequential write stores data bits 7:0, zero-extended to 10 bits.
- R8: A write to the index register loads the index and clears the component counter, including in the middle of an entry.
- R9: In linear mode the index wraps from 255 to 0.
- R10: A packed write in segment mode changes no table, index or counter. It sets `err_flag`, which stays set until reset.
- R11: The two tables are separate. A segment write never changes a linear entry with the same low address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Register write beat valid |
| wr_ready | output | 1 | Write beat accepted (always 1) |
| wr_addr | input | 3 | Register select |
| wr_data | input | DATA_W | Register write data |
| upd_valid | output | 1 | Entry updated event, one cycle |
| upd_pwl | output | 1 | Event table: 1 = segment, 0 = linear |
| upd_index | output | 8 | Entry address of the event |
| upd_red | output | 16 | Red channel of the updated entry |
| upd_green | output | 16 | Green channel of the updated entry |
| upd_blue | output | 16 | Blue channel of the updated entry |
| cur_index | output | 8 | Current index register |
| cur_mode | output | 1 | Current table mode |
| err_flag | output | 1 | Sticky wrong-mode write flag |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Opposed orders.** Data arrives red first while mask bit 0 means blue. A design that reused one order for both would store the wrong channel or drop the enabled one.
- **Disabled components.** With only blue enabled, red and green must still advance the counter. Otherwise the blue value would land late, or the index would stall.
- **Counter reset.** An index write made partway through an entry, and a packed write made partway through an entry, must both restart the counter at red. A design that kept the counter would put the next value in green.
- **Wrap and table separation.** The bench checks the linear wrap from 255 to 0, the 7-bit segment wrap that must keep bit 7, the wrong-mode packed write that must leave the index alone and set the flag, and a segment write at address 5 that must leave linear entry 5 intact.

// File: rtl/gamma_lut_pkg.sv
`timescale 1ns/1ps
package gamma_lut_pkg;
  localparam int ADDR_W   = 3;
  localparam int IDX_W    = 8;
  localparam int CH_N     = 3;
  localparam int CH_MAX_W = 16;

  localparam logic [ADDR_W-1:0] REG_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_INDEX = 3'd1;
  localparam logic [ADDR_W-1:0] REG_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_SEQ   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_PACK  = 3'd4;

  // Channel slot order inside the write request: 0 red, 1 green, 2 blue.
  typedef struct packed {
    logic                              pwl;
    logic [CH_N-1:0]                   we;
    logic [IDX_W-1:0]                  addr;
    logic [CH_N-1:0][CH_MAX_W-1:0]     data;
    logic                              ev;
  } lut_wr_t;
endpackage

// File: rtl/gamma_lut_mem.sv
`timescale 1ns/1ps
module gamma_lut_mem #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 10,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  // Same address for read and write: the read shows the entry before this cycle's write.
  assign rdata = mem[addr];
endmodule

// File: rtl/gamma_lut_ctrl.sv
`timescale 1ns/1ps
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIN_W  = 10,
  parameter int PWL_W  = 16,
  parameter int SEQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output lut_wr_t           wr,
  output logic [IDX_W-1:0]  index,
  output logic              mode,
  output logic              err
);
  logic [IDX_W-1:0]    idx_q, idx_d, idx_step, entry;
  logic [1:0]          comp_q, comp_d;
  logic [CH_N-1:0]     mask_q, mask_d;
  logic                mode_q, mode_d, err_q, err_d;
  logic [CH_MAX_W-1:0] seq_val;
  logic                unused_hi;

  assign unused_hi = ^data[DATA_W-1:CH_N*LIN_W];

  always_comb begin
    // Segment mode keeps bit 7 and wraps the low bits; linear mode wraps all 8 bits.
    idx_step = mode_q ? {idx_q[IDX_W-1], idx_q[IDX_W-2:0] + 1'b1} : idx_q + 1'b1;
    entry    = mode_q ? {1'b0, idx_q[IDX_W-2:0]} : idx_q;
    seq_val  = mode_q ? CH_MAX_W'(data[PWL_W-1:0]) : CH_MAX_W'(data[SEQ_W-1:0]);

    wr      = '0;
    wr.pwl  = mode_q;
    wr.addr = entry;
    idx_d   = idx_q;
    comp_d  = comp_q;
    mask_d  = mask_q;
    mode_d  = mode_q;
    err_d   = err_q;

    if (acc) begin
      case (addr)
        REG_MODE:  mode_d = data[0];
        REG_INDEX: begin
          idx_d  = data[IDX_W-1:0];
          comp_d = '0;
        end
        REG_MASK:  mask_d = data[CH_N-1:0];
        REG_SEQ: begin
          for (int c = 0; c < CH_N; c++) begin
            wr.data[c] = seq_val;
            // Mask is stored blue-first, so channel slot c maps to bit CH_N-1-c.
            if (comp_q == 2'(c)) wr.we[c] = mask_q[CH_N-1-c];
          end
          if (comp_q == 2'(CH_N-1)) begin
            comp_d = '0;
            idx_d  = idx_step;
          end else begin
            comp_d = comp_q + 1'b1;
          end
        end
        REG_PACK: begin
          if (mode_q) begin
            err_d = 1'b1;
          end else begin
            for (int c = 0; c < CH_N; c++) begin
              wr.data[c] = CH_MAX_W'(data[(CH_N-1-c)*LIN_W +: LIN_W]);
              wr.we[c]   = mask_q[CH_N-1-c];
            end
            idx_d  = idx_step;
            comp_d = '0;
          end
        end
        default: ;
      endcase
    end
    wr.ev = |wr.we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      comp_q <= '0;
      mask_q <= '0;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      comp_q <= comp_d;
      mask_q <= mask_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign index = idx_q;
  assign mode  = mode_q;
  assign err   = err_q;
endmodule

// File: rtl/gamma_lut_wr.sv
`timescale 1ns/1ps
module gamma_lut_wr
  import gamma_lut_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIN_W  = 10,
  parameter int PWL_W  = 16,
  parameter int SEQ_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                upd_valid,
  output logic                upd_pwl,
  output logic [IDX_W-1:0]    upd_index,
  output logic [CH_MAX_W-1:0] upd_red,
  output logic [CH_MAX_W-1:0] upd_green,
  output logic [CH_MAX_W-1:0] upd_blue,
  output logic [IDX_W-1:0]    cur_index,
  output logic                cur_mode,
  output logic                err_flag
);
  localparam int LIN_DEPTH = 1 << IDX_W;
  localparam int PWL_AW    = IDX_W - 1;
  localparam int PWL_DEPTH = 1 << PWL_AW;

  lut_wr_t                       wr;
  logic [CH_N-1:0][CH_MAX_W-1:0] view;
  logic [CH_N-1:0][CH_MAX_W-1:0] upd_ch;
  logic                          acc;

  assign wr_ready = 1'b1;
  assign acc      = wr_valid & wr_ready;

  gamma_lut_ctrl #(
    .DATA_W(DATA_W), .LIN_W(LIN_W), .PWL_W(PWL_W), .SEQ_W(SEQ_W)
  ) i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .acc   (acc),
    .addr  (wr_addr),
    .data  (wr_data),
    .wr    (wr),
    .index (cur_index),
    .mode  (cur_mode),
    .err   (err_flag)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [LIN_W-1:0] lin_rd;
    logic [PWL_W-1:0] pwl_rd;

    gamma_lut_mem #(.DEPTH(LIN_DEPTH), .WIDTH(LIN_W)) i_lin (
      .clk   (clk),
      .rst   (rst),
      .we    (wr.we[c] & ~wr.pwl),
      .addr  (wr.addr),
      .wdata (wr.data[c][LIN_W-1:0]),
      .rdata (lin_rd)
    );

    gamma_lut_mem #(.DEPTH(PWL_DEPTH), .WIDTH(PWL_W)) i_pwl (
      .clk   (clk),
      .rst   (rst),
      .we    (wr.we[c] & wr.pwl),
      .addr  (wr.addr[PWL_AW-1:0]),
      .wdata (wr.data[c][PWL_W-1:0]),
      .rdata (pwl_rd)
    );

    // Entry contents as they stand once this cycle's write has landed.
    assign view[c] = wr.we[c] ? wr.data[c]
                   : (wr.pwl ? CH_MAX_W'(pwl_rd) : CH_MAX_W'(lin_rd));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid <= 1'b0;
      upd_pwl   <= 1'b0;
      upd_index <= '0;
      upd_ch    <= '0;
    end else begin
      upd_valid <= wr.ev;
      if (wr.ev) begin
        upd_pwl   <= wr.pwl;
        upd_index <= wr.addr;
        upd_ch    <= view;
      end
    end
  end

  assign upd_red   = upd_ch[0];
  assign upd_green = upd_ch[1];
  assign upd_blue  = upd_ch[2];
endmodule

// File: rtl/gamma_lut_wr_chk.sv
`timescale 1ns/1ps
module gamma_lut_wr_chk
  import gamma_lut_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [IDX_W-1:0]  wr_data_lo,
  input logic              upd_valid,
  input logic              upd_pwl,
  input logic [IDX_W-1:0]  upd_index,
  input logic [IDX_W-1:0]  cur_index,
  input logic              cur_mode,
  input logic              err_flag
);
  logic acc;
  assign acc = wr_valid & wr_ready;

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(acc && wr_addr == REG_MODE) |=> cur_mode == $past(cur_mode));

  assert_event_cause_R5: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $past(acc) && ($past(wr_addr) == REG_SEQ || $past(wr_addr) == REG_PACK));

  assert_pwl_bit7_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_addr == REG_SEQ && cur_mode) |=> cur_index[IDX_W-1] == $past(cur_index[IDX_W-1]));

  assert_pwl_event_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_pwl) |-> !upd_index[IDX_W-1]);

  assert_pack_step_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_addr == REG_PACK && !cur_mode) |=> cur_index == IDX_W'($past(cur_index) + 1'b1));

  assert_index_load_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_addr == REG_INDEX) |=> cur_index == $past(wr_data_lo));

  assert_pack_wrong_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_addr == REG_PACK && cur_mode) |=> err_flag && cur_index == $past(cur_index));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
endmodule

bind gamma_lut_wr gamma_lut_wr_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data_lo (wr_data[gamma_lut_pkg::IDX_W-1:0]),
  .upd_valid  (upd_valid),
  .upd_pwl    (upd_pwl),
  .upd_index  (upd_index),
  .cur_index  (cur_index),
  .cur_mode   (cur_mode),
  .err_flag   (err_flag)
);

// File: tb/test_gamma_lut_wr.sv
`timescale 1ns/1ps
module test_gamma_lut_wr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        upd_valid, upd_pwl, cur_mode, err_flag;
  logic [7:0]  upd_index, cur_index;
  logic [15:0] upd_red, upd_green, upd_blue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gamma_lut_wr i_gamma_lut_wr (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .upd_valid(upd_valid),
    .upd_pwl(upd_pwl), .upd_index(upd_index), .upd_red(upd_red),
    .upd_green(upd_green), .upd_blue(upd_blue), .cur_index(cur_index),
    .cur_mode(cur_mode), .err_flag(err_flag)
  );

  // Vector: {addr, data, event, pwl, event index, red, green, blue, index after, error after}
  localparam int NV = 40;
  localparam logic [101:0] VEC [NV] = '{
    {3'd2, 32'h00000007, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0},
    {3'd1, 32'h00000005, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h05, 1'b0},
    {3'd3, 32'h00000011, 1'b1, 1'b0, 8'h05, 16'h0011, 16'h0000, 16'h0000, 8'h05, 1'b0},
    {3'd3, 32'h00000022, 1'b1, 1'b0, 8'h05, 16'h0011, 16'h0022, 16'h0000, 8'h05, 1'b0},
    {3'd3, 32'h0001FF33, 1'b1, 1'b0, 8'h05, 16'h0011, 16'h0022, 16'h0033, 8'h06, 1'b0},
    {3'd2, 32'h00000001, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h06, 1'b0},
    {3'd3, 32'h00000044, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h06, 1'b0},
    {3'd3, 32'h00000055, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h06, 1'b0},
    {3'd3, 32'h00000066, 1'b1, 1'b0, 8'h06, 16'h0000, 16'h0000, 16'h0066, 8'h07, 1'b0},
    {3'd2, 32'h00000004, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h07, 1'b0},
    {3'd3, 32'h00000077, 1'b1, 1'b0, 8'h07, 16'h0077, 16'h0000, 16'h0000, 8'h07, 1'b0},
    {3'd1, 32'h00000007, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h07, 1'b0},
    {3'd3, 32'h00000088, 1'b1, 1'b0, 8'h07, 16'h0088, 16'h0000, 16'h0000, 8'h07, 1'b0},
    {3'd2, 32'h00000007, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h07, 1'b0},
    {3'd4, 32'h3FF556AA, 1'b1, 1'b0, 8'h07, 16'h03FF, 16'h0155, 16'h02AA, 8'h08, 1'b0},
    {3'd3, 32'h00000001, 1'b1, 1'b0, 8'h08, 16'h0001, 16'h0000, 16'h0000, 8'h08, 1'b0},
    {3'd2, 32'h00000002, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h08, 1'b0},
    {3'd4, 32'h3FF556AA, 1'b1, 1'b0, 8'h08, 16'h0001, 16'h0155, 16'h0000, 8'h09, 1'b0},
    {3'd2, 32'h00000000, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h09, 1'b0},
    {3'd4, 32'h3FF556AA, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h0A, 1'b0},
    {3'd1, 32'h000000FF, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'hFF, 1'b0},
    {3'd2, 32'h00000007, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'hFF, 1'b0},
    // R9: linear index wraps 255 -> 0
    {3'd4, 32'h00100401, 1'b1, 1'b0, 8'hFF, 16'h0001, 16'h0001, 16'h0001, 8'h00, 1'b0},
    {3'd0, 32'h00000001, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0},
    {3'd1, 32'h00000085, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h85, 1'b0},
    {3'd3, 32'h1234ABCD, 1'b1, 1'b1, 8'h05, 16'hABCD, 16'h0000, 16'h0000, 8'h85, 1'b0},
    {3'd3, 32'h0000BEEF, 1'b1, 1'b1, 8'h05, 16'hABCD, 16'hBEEF, 16'h0000, 8'h85, 1'b0},
    {3'd3, 32'h0000CAFE, 1'b1, 1'b1, 8'h05, 16'hABCD, 16'hBEEF, 16'hCAFE, 8'h86, 1'b0},
    {3'd1, 32'h000000FF, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'hFF, 1'b0},
    {3'd3, 32'h00000001, 1'b1, 1'b1, 8'h7F, 16'h0001, 16'h0000, 16'h0000, 8'hFF, 1'b0},
    {3'd3, 32'h00000002, 1'b1, 1'b1, 8'h7F, 16'h0001, 16'h0002, 16'h0000, 8'hFF, 1'b0},
    {3'd3, 32'h00000003, 1'b1, 1'b1, 8'h7F, 16'h0001, 16'h0002, 16'h0003, 8'h80, 1'b0},
    {3'd4, 32'h3FF556AA, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h80, 1'b1},
    {3'd0, 32'h00000000, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h80, 1'b1},
    {3'd1, 32'h00000005, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h05, 1'b1},
    {3'd2, 32'h00000001, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h05, 1'b1},
    {3'd3, 32'h00000099, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h05, 1'b1},
    {3'd3, 32'h00000099, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h05, 1'b1},
    // R11: linear entry 5 kept its contents after the segment writes at address 5
    {3'd3, 32'h00000033, 1'b1, 1'b0, 8'h05, 16'h0011, 16'h0022, 16'h0033, 8'h06, 1'b1},
    {3'd7, 32'hFFFFFFFF, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h06, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the accepting rising edge.
  task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [2:0]  a;
    logic [31:0] d;
    logic        ev, pw, er;
    logic [7:0]  ui, ix;
    logic [15:0] r, g, b;
    string       tag;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 ready
    check("R1", "cur_index", 32'(cur_index), 32'h0);
    check("R1", "cur_mode", 32'(cur_mode), 32'h0);
    check("R1", "err_flag", 32'(err_flag), 32'h0);
    check("R1", "upd_valid", 32'(upd_valid), 32'h0);
    check("R2", "wr_ready", 32'(wr_ready), 32'h1);

    for (int i = 0; i < NV; i++) begin
      {a, d, ev, pw, ui, r, g, b, ix, er} = VEC[i];
      if (a == 3'd1) tag = "R8";
      else if (a == 3'd3) tag = cur_mode ? "R6" : "R3";
      else if (a == 3'd4) tag = cur_mode ? "R10" : "R7";
      else tag = "R2";
      write_reg(a, d);
      check("R5", $sformatf("vec%0d upd_valid", i), 32'(upd_valid), 32'(ev));
      check(tag, $sformatf("vec%0d cur_index", i), 32'(cur_index), 32'(ix));
      check("R10", $sformatf("vec%0d err_flag", i), 32'(err_flag), 32'(er));
      if (ev) begin
        check("R6", $sformatf("vec%0d upd_pwl", i), 32'(upd_pwl), 32'(pw));
        check("R5", $sformatf("vec%0d upd_index", i), 32'(upd_index), 32'(ui));
        check("R4", $sformatf("vec%0d upd_red", i), 32'(upd_red), 32'(r));
        check("R4", $sformatf("vec%0d upd_green", i), 32'(upd_green), 32'(g));
        check("R4", $sformatf("vec%0d upd_blue", i), 32'(upd_blue), 32'(b));
      end
    end
    check("R2", "mode after stray address", 32'(cur_mode), 32'h0);

    // R1: reset in mid-run clears registers, flag, mask and table contents
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1", "err_flag after reset", 32'(err_flag), 32'h0);
    check("R1", "cur_index after reset", 32'(cur_index), 32'h0);
    check("R1", "cur_mode after reset", 32'(cur_mode), 32'h0);
    write_reg(3'd3, 32'h5);
    check("R1", "no event with cleared mask", 32'(upd_valid), 32'h0);
    write_reg(3'd1, 32'hFF);
    write_reg(3'd2, 32'h7);
    write_reg(3'd3, 32'h5);
    check("R1", "event after reset", 32'(upd_valid), 32'h1);
    check("R1", "red", 32'(upd_red), 32'h5);
    check("R1", "green cleared", 32'(upd_green), 32'h0);
    check("R1", "blue cleared", 32'(upd_blue), 32'h0);
    @(negedge clk);
    check("R5", "event lasts one cycle", 32'(upd_valid), 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule